// File: doc/BRIEF.md
# Event Interrupter with Rate Moderation

This block turns a stream of "event posted" strobes from an event ring into a throttled interrupt request. Events are remembered in an internal outstanding flag. Events that arrive close together collapse into a single interrupt. A new interrupt is raised only under three conditions: a moderation down-counter has run out, at least one event is outstanding, and software's handler is not marked busy.

Software controls the block through three 32-bit registers, selected by a 2-bit address. The control word holds the pending flag, the enable bit and general-purpose upper bits. The moderation word holds a programmable interval and the live down-counter. The dequeue word holds a segment-index hint, the handler-busy flag and the upper pointer bits. The counter counts in units of an external tick enable, which is normally one pulse every 250 ns. When an interrupt fires, the counter reloads from the interval, so the interval sets the minimum spacing between interrupts. The request line combines the pending flag, the local enable and a global enable input.

Top module: `irqm_moderator`

## Requirements
- R1: After reset the control word reads 0, the moderation word reads 0x00000FA0 (interval 4000, counter 0), the dequeue word reads 0, address 3 reads 0, and irq_req is low.
- R2: Control word (address 0): bit 0 is pending and is cleared by writing 1 to it (writing 0 has no effect). Bit 1 is enable and takes the written value. Bits 31:2 read back what was last written.
- R3: Moderation word (address 1): bits 15:0 are the interval and read back as written. A write also loads the counter, in bits 31:16, from the written bits 31:16.
- R4: Dequeue word (address 2): bits 2:0 are the segment index and bits 31:4 read back as written. Bit 3 is handler-busy, and writing 1 to it clears it.
- R5: In a cycle where the counter is 0, an event is outstanding and handler-busy is clear, pending and handler-busy both read 1 after the next clock edge.
- R6: On firing, the counter loads the interval. Otherwise it drops by one on each clock edge where tick is high, holds when tick is low, and stays at 0 once it gets there.
- R7: If the counter reaches 0 with no event outstanding, nothing fires until an event arrives. The interrupt then fires on the second edge after the event strobe.
- R8: While handler-busy is set, no new interrupt fires. Once it is cleared, any outstanding event fires as soon as the counter is 0.
- R9: irq_req is high exactly when pending, enable and glb_irq_en are all 1.
- R10: Events that arrive before a firing are consumed by it. Several such events give one interrupt only, and an event strobe in the firing cycle itself is kept for the next interrupt.
- R11: If firing and a write that clears pending happen in the same cycle, pending ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_post | input | 1 | One-cycle strobe: an event was placed on the ring |
| tick | input | 1 | Moderation time base enable (one 250 ns unit) |
| glb_irq_en | input | 1 | Global interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 moderation, 2 dequeue |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_req | output | 1 | Interrupt request |

## Verification
The main function is tried with four kinds of event pattern:
- A single strobe onto an expired counter, which shows the two-edge latency from strobe to firing.
- A burst of strobes while the handler is busy, which shows that strobes are remembered without firing early and that the burst collapses into one interrupt.
- A long quiet stretch after the counter expires, which shows that an interrupt is deferred, not lost.
- A strobe timed so that firing lands on a software clear of pending, which checks which of the two wins.

Tick is also held low for a while to separate "counter holding" from "counter stuck", and the global enable is toggled to separate the request gate from the pending state.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_MOD  = 2'd1,
    RA_DEQ  = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  // Saturating step of the moderation counter: one unit per tick, floor at 0.
  function automatic logic [REG_W-1:0] cnt_step(input logic [REG_W-1:0] cur,
                                                 input logic tk);
    if (tk && (cur != '0)) return cur - 1'b1;
    return cur;
  endfunction

  // Moderation word: interval in the low half, live counter in the high half.
  function automatic logic [REG_W-1:0] mod_pack(input logic [REG_W-1:0] ivl,
                                                 input logic [REG_W-1:0] cnt,
                                                 input int half);
    logic [REG_W-1:0] mask;
    mask = (REG_W'(1) << half) - 1'b1;
    return ((cnt & mask) << half) | (ivl & mask);
  endfunction

endpackage

// File: rtl/irqm_countdown.sv
module irqm_countdown import irqm_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (wr_i)   cnt_q <= wr_val_i;
    else             cnt_q <= CNT_W'(cnt_step(REG_W'(cnt_q), tick_i));
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  // R6: one unit down per tick while running
  a_r6_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && !wr_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R6: an expired counter stays expired until reloaded
  a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !wr_i && cnt_q == '0) |=> (cnt_q == '0));

  // R6: no tick, no movement
  a_r6_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i && !wr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/irqm_flags.sv
module irqm_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic cnt_zero_i,
  input  logic pend_clr_i,
  input  logic busy_clr_i,
  output logic pend_o,
  output logic busy_o,
  output logic fire_o
);

  logic pend_q, busy_q, outst_q;
  logic fire;

  assign fire = cnt_zero_i && outst_q && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      busy_q  <= 1'b0;
      outst_q <= 1'b0;
    end else begin
      if (fire)            pend_q <= 1'b1;
      else if (pend_clr_i) pend_q <= 1'b0;
      if (fire)            busy_q <= 1'b1;
      else if (busy_clr_i) busy_q <= 1'b0;
      outst_q <= evt_i || (outst_q && !fire);
    end
  end

  assign pend_o = pend_q;
  assign busy_o = busy_q;
  assign fire_o = fire;

  // R5: a firing sets both pending and handler-busy
  a_r5_fire_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (pend_q && busy_q));

  // R5: pending only rises after an expired counter with work waiting
  a_r5_pend_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(cnt_zero_i && outst_q));

  // R8: busy stays set until software clears it
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !busy_clr_i) |=> busy_q);

  // R10: an event strobe is never dropped
  a_r10_evt_kept: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> outst_q);

  // R11: firing beats a same-cycle clear
  a_r11_fire_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && pend_clr_i) |=> pend_q);

endmodule

// File: rtl/irqm_moderator.sv
module irqm_moderator import irqm_pkg::*; #(
  parameter int IVL_W   = 16,
  parameter int SEG_W   = 3,
  parameter int DEF_IVL = 4000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evt_post,
  input  logic        tick,
  input  logic        glb_irq_en,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_req
);

  localparam int BUSY_BIT = SEG_W;
  localparam int DHI_LO   = SEG_W + 1;
  localparam int CNT_LO   = IVL_W;
  localparam int CNT_HI   = 2 * IVL_W - 1;

  logic wr_ctrl, wr_mod, wr_deq;
  logic en_q;
  logic [REG_W-1:2]      chi_q;
  logic [IVL_W-1:0]      ivl_q;
  logic [SEG_W-1:0]      seg_q;
  logic [REG_W-1:DHI_LO] dhi_q;
  logic [IVL_W-1:0]      cnt;
  logic cnt_zero, pend, busy, fire;

  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_mod  = reg_wr && (reg_addr == RA_MOD);
  assign wr_deq  = reg_wr && (reg_addr == RA_DEQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      chi_q <= '0;
      ivl_q <= IVL_W'(DEF_IVL);
      seg_q <= '0;
      dhi_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= reg_wdata[1];
        chi_q <= reg_wdata[REG_W-1:2];
      end
      if (wr_mod) ivl_q <= reg_wdata[IVL_W-1:0];
      if (wr_deq) begin
        seg_q <= reg_wdata[SEG_W-1:0];
        dhi_q <= reg_wdata[REG_W-1:DHI_LO];
      end
    end
  end

  irqm_countdown #(.CNT_W(IVL_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .load_i     (fire),
    .load_val_i (ivl_q),
    .wr_i       (wr_mod),
    .wr_val_i   (reg_wdata[CNT_HI:CNT_LO]),
    .cnt_o      (cnt),
    .zero_o     (cnt_zero)
  );

  irqm_flags u_flg (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_post),
    .cnt_zero_i (cnt_zero),
    .pend_clr_i (wr_ctrl && reg_wdata[0]),
    .busy_clr_i (wr_deq && reg_wdata[BUSY_BIT]),
    .pend_o     (pend),
    .busy_o     (busy),
    .fire_o     (fire)
  );

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = {chi_q, en_q, pend};
      RA_MOD:  reg_rdata = mod_pack(REG_W'(ivl_q), REG_W'(cnt), IVL_W);
      RA_DEQ:  reg_rdata = {dhi_q, busy, seg_q};
      default: reg_rdata = '0;
    endcase
  end

  assign irq_req = pend && en_q && glb_irq_en;

  // R2: enable only moves on a control write
  a_r2_en_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(en_q));

  // R3: interval only moves on a moderation write
  a_r3_ivl_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mod |=> $stable(ivl_q));

  // R6: a firing reloads the counter with the interval
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt == $past(ivl_q)));

  // R8: no firing while handler is busy
  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fire);

endmodule

// File: tb/test_irqm_moderator.sv
module test_irqm_moderator;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_post = 1'b0;
  logic        tick = 1'b0;
  logic        glb_irq_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_req;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqm_moderator i_irqm_moderator (
    .clk(clk), .rst_n(rst_n), .evt_post(evt_post), .tick(tick),
    .glb_irq_en(glb_irq_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req)
  );

  // Behavioural reference model
  int m_pend, m_en, m_busy, m_outst, m_seg;
  int unsigned m_chi, m_ivl, m_cnt, m_dhi;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_en = 0; m_busy = 0; m_outst = 0; m_seg = 0;
      m_chi = 0; m_ivl = 4000; m_cnt = 0; m_dhi = 0;
    end else begin
      int fire;
      int unsigned n_cnt;
      fire = (m_cnt == 0 && m_outst != 0 && m_busy == 0) ? 1 : 0;
      n_cnt = m_cnt;
      if (fire != 0) n_cnt = m_ivl;
      else if (reg_wr && reg_addr == 2'd1) n_cnt = reg_wdata >> 16;
      else if (tick && m_cnt > 0) n_cnt = m_cnt - 1;
      m_outst = (evt_post || (m_outst != 0 && fire == 0)) ? 1 : 0;
      if (fire != 0) begin m_pend = 1; m_busy = 1; end
      else begin
        if (reg_wr && reg_addr == 2'd0 && reg_wdata[0]) m_pend = 0;
        if (reg_wr && reg_addr == 2'd2 && reg_wdata[3]) m_busy = 0;
      end
      if (reg_wr && reg_addr == 2'd0) begin m_en = reg_wdata[1]; m_chi = reg_wdata >> 2; end
      if (reg_wr && reg_addr == 2'd1) m_ivl = reg_wdata & 32'hFFFF;
      if (reg_wr && reg_addr == 2'd2) begin m_seg = reg_wdata & 7; m_dhi = reg_wdata >> 4; end
      m_cnt = n_cnt;
    end
  end

  function automatic logic [31:0] model_rd(input logic [1:0] a);
    case (a)
      2'd0: return (m_chi << 2) | (m_en << 1) | m_pend;
      2'd1: return (m_cnt << 16) | m_ivl;
      2'd2: return (m_dhi << 4) | (m_busy << 3) | m_seg;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      case (reg_addr)
        2'd0: chk("R2 ctrl word", reg_rdata, model_rd(reg_addr));
        2'd1: chk("R3 moderation word", reg_rdata, model_rd(reg_addr));
        2'd2: chk("R4 dequeue word", reg_rdata, model_rd(reg_addr));
        default: chk("R1 unused addr", reg_rdata, model_rd(reg_addr));
      endcase
      chk("R9 irq_req", {31'd0, irq_req},
          {31'd0, (m_pend != 0 && m_en != 0 && glb_irq_en)});
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    cyc(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
    @(posedge clk); #2;
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    @(negedge clk);
    chk(tag, {31'd0, irq_req}, {31'd0, exp});
    @(posedge clk); #2;
  endtask

  task automatic pulse_evt();
    evt_post = 1'b1;
    cyc(1);
    evt_post = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick = 1'b1;
    // R1 reset values
    rd_chk(2'd0, 32'h0, "R1 ctrl reset");
    rd_chk(2'd1, 32'h0000_0FA0, "R1 moderation reset");
    rd_chk(2'd2, 32'h0, "R1 dequeue reset");
    rd_chk(2'd3, 32'h0, "R1 addr3 reads zero");
    irq_chk(1'b0, "R1 irq low after reset");
    // R2 control word fields
    wr(2'd0, 32'hABCD_0006);
    rd_chk(2'd0, 32'hABCD_0006, "R2 enable and upper bits");
    wr(2'd0, 32'hABCD_0007);
    rd_chk(2'd0, 32'hABCD_0006, "R2 W1C on clear pending no effect");
    // R3 moderation word
    wr(2'd1, 32'h0000_0005);
    rd_chk(2'd1, 32'h0000_0005, "R3 interval write");
    wr(2'd1, 32'h0003_0005);
    rd_chk(2'd1, 32'h0003_0005, "R3 counter load");
    cyc(5);
    rd_chk(2'd1, 32'h0000_0005, "R6 counter floors at zero");
    // R5 single event onto expired counter
    glb_irq_en = 1'b1;
    pulse_evt();
    rd_chk(2'd0, 32'hABCD_0006, "R5 not yet pending one edge after strobe");
    rd_chk(2'd0, 32'hABCD_0007, "R5 pending set");
    rd_chk(2'd2, 32'h0000_0008, "R5 busy set");
    irq_chk(1'b1, "R9 irq high");
    glb_irq_en = 1'b0;
    irq_chk(1'b0, "R9 global gate");
    glb_irq_en = 1'b1;
    // R8/R10 burst while busy
    pulse_evt(); cyc(1); pulse_evt(); pulse_evt();
    cyc(10);
    rd_chk(2'd2, 32'h0000_0008, "R8 busy still set, no refire");
    wr(2'd0, 32'hABCD_0007);
    rd_chk(2'd0, 32'hABCD_0006, "R2 pending cleared by W1C");
    irq_chk(1'b0, "R9 irq low after clear");
    cyc(4);
    rd_chk(2'd0, 32'hABCD_0006, "R8 no fire while busy");
    wr(2'd2, 32'h1234_567D);
    rd_chk(2'd2, 32'h1234_5675, "R4 busy W1C and fields");
    rd_chk(2'd0, 32'hABCD_0007, "R8 outstanding fires after busy clear");
    rd_chk(2'd2, 32'h1234_567D, "R8 busy set again");
    wr(2'd0, 32'hABCD_0007);
    wr(2'd2, 32'h1234_567D);
    cyc(20);
    rd_chk(2'd0, 32'hABCD_0006, "R10 burst gave one interrupt");
    // R7 quiet period then event
    cyc(10);
    irq_chk(1'b0, "R7 no fire without event");
    pulse_evt();
    rd_chk(2'd0, 32'hABCD_0006, "R7 first edge after strobe");
    rd_chk(2'd0, 32'hABCD_0007, "R7 fires on second edge");
    // R6 tick low holds the counter
    tick = 1'b0;
    wr(2'd1, 32'h0007_0005);
    cyc(4);
    rd_chk(2'd1, 32'h0007_0005, "R6 hold with tick low");
    tick = 1'b1;
    cyc(3);
    rd_chk(2'd1, 32'h0004_0005, "R6 decrement per tick");
    // R11 firing collides with a pending clear
    wr(2'd2, 32'h0000_0008);
    cyc(10);
    pulse_evt();
    wr(2'd0, 32'hABCD_0007);
    rd_chk(2'd0, 32'hABCD_0007, "R11 fire wins over clear");
    // R10 strobe in the firing cycle is kept
    wr(2'd0, 32'hABCD_0007);
    wr(2'd2, 32'h0000_0008);
    wr(2'd1, 32'h0000_0002);
    pulse_evt();
    pulse_evt();
    wr(2'd0, 32'hABCD_0007);
    wr(2'd2, 32'h0000_0008);
    cyc(6);
    rd_chk(2'd0, 32'hABCD_0007, "R10 strobe in firing cycle refires");
    cyc(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule